// File: doc/BRIEF.md
# Serial Flash Identification Responder

This block is a behavioural SPI target that answers the identification query of a serial flash. A master under test drives chip select, the serial clock and the data line towards it, and reads the identity back on the return line. Every incoming pin is brought into the system clock domain through a synchronizer. Edges of the serial clock are found by comparing samples in that domain, so all state is clocked by the system clock.

The first byte after selection is the command. While it is still being shifted in, the return line carries a placeholder byte of all ones, because the command is not yet known. When the command is the identification opcode, the next three byte times return a fixed three-byte identity. Once the identity has been sent, the line returns all ones. Any other command returns all ones until the master deselects. Raising chip select at any point throws the command away, and the next selection starts from the command byte.

The return line has an output enable that is low whenever the block is not selected; this stands in for a tri-stated pin. The pins are plain serial pins, so there is no valid/ready stream at the edge and no back-pressure: the master paces every bit with its clock. The system clock must run at least four times the serial clock.

Top module: `flash_id_responder`

## Requirements
- R1: While chip select is high, `miso_oe` is 0 and `miso_o` is 1. Within four system clocks of chip select falling, `miso_oe` becomes 1.
- R2: During the eight serial clocks of the command byte, the bits sampled on `miso_o` form 0xFF.
- R3: When the command byte is 0x9F, the next three bytes on `miso_o` are 0x01, 0x40 and 0x13, in that order, each most significant bit first.
- R4: After the third identity byte, every further byte read in the same selection is 0xFF.
- R5: A command byte other than 0x9F makes every following byte of that selection read 0xFF.
- R6: Raising chip select at any point discards the partial command or the response in progress. The next selection decodes a new command byte starting from bit 7.
- R7: Serial clock modes 0 (idle low) and 3 (idle high) both work. `mosi_pin` is sampled on rising edges and `miso_o` changes only after falling edges, never between them while selected.
- R8: Serial clock edges that occur while `wp_n_pin` or `hold_n_pin` is low are ignored. They neither shift a command bit nor advance the response.
- R9: Each pin passes through a two-flop synchronizer. A rising and a falling serial clock edge are never detected in adjacent system cycles, which holds when the system clock is at least four times the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select from the master, active low |
| sck_pin | input | 1 | Serial clock from the master |
| mosi_pin | input | 1 | Serial data from the master |
| wp_n_pin | input | 1 | Write-protect level, expected high |
| hold_n_pin | input | 1 | Hold level, expected high |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso_o`, high while selected |

## Verification
The hardest situation to reach is a deselection in the middle of a byte, or in the middle of the identity, followed at once by a new command. Only the next selection shows whether stale bit counts or byte indices survived. The stimulus cuts a 0x9F command off after four bits, and separately cuts a valid identity response off after its first byte. Each cut is followed by a fresh selection whose bytes expose any leftover state. A held sequence also clocks a full byte with the hold level low, then sends 0x9F to prove those edges left nothing behind.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

  typedef enum logic [1:0] {
    ST_OPCODE = 2'd0,
    ST_IDENT  = 2'd1,
    ST_FILL   = 2'd2
  } resp_state_e;

  localparam logic [7:0]  DEF_OPCODE   = 8'h9F;
  localparam logic [7:0]  DEF_FILL     = 8'hFF;
  localparam int          DEF_ID_BYTES = 3;
  localparam logic [23:0] DEF_ID_VALUE = 24'h01_40_13;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int               WIDTH   = 5,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sck_edge_detect.sv
module sck_edge_detect #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic enable,
  output logic rise,
  output logic fall
);

  logic sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= RST_LEVEL;
    else        sck_prev <= sck_s;
  end

  // Previous sample always tracks the pin; only the pulses are gated,
  // so re-enabling never manufactures an edge.
  assign rise = enable &  sck_s & ~sck_prev;
  assign fall = enable & ~sck_s &  sck_prev;

endmodule

// File: rtl/id_engine.sv
module id_engine
  import flash_id_pkg::*;
#(
  parameter logic [7:0]            OPCODE   = DEF_OPCODE,
  parameter logic [7:0]            FILL     = DEF_FILL,
  parameter int                    ID_BYTES = DEF_ID_BYTES,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE = DEF_ID_VALUE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        rise,
  input  logic        fall,
  input  logic        mosi_bit,
  output logic        miso_bit,
  output resp_state_e state
);

  localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BYTES - 1);

  logic [7:0]       id_tab [ID_BYTES];
  logic [2:0]       bit_cnt;
  logic [6:0]       rx_sr;
  logic [IDX_W-1:0] idx;
  logic [7:0]       cur_byte;
  logic [7:0]       rx_byte;

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    assign id_tab[g] = ID_VALUE[8*(ID_BYTES-1-g) +: 8];
  end

  assign rx_byte = {rx_sr, mosi_bit};

  always_comb begin
    case (state)
      ST_IDENT: cur_byte = id_tab[idx];
      default:  cur_byte = FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OPCODE;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      idx      <= '0;
      miso_bit <= FILL[7];
    end else if (!sel) begin
      state    <= ST_OPCODE;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      idx      <= '0;
      miso_bit <= FILL[7];
    end else begin
      if (rise) begin
        rx_sr   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (state)
            ST_OPCODE: begin
              idx   <= '0;
              state <= (rx_byte == OPCODE) ? ST_IDENT : ST_FILL;
            end
            ST_IDENT: begin
              if (idx == LAST_IDX) state <= ST_FILL;
              else                 idx   <= idx + 1'b1;
            end
            default: state <= ST_FILL;
          endcase
        end
      end
      if (fall) begin
        // bit_cnt bits of the current byte have been clocked: present bit 7-bit_cnt
        miso_bit <= cur_byte[~bit_cnt];
      end
    end
  end

endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
  import flash_id_pkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter logic [7:0]            OPCODE      = DEF_OPCODE,
  parameter logic [7:0]            FILL        = DEF_FILL,
  parameter int                    ID_BYTES    = DEF_ID_BYTES,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE    = DEF_ID_VALUE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic mosi_pin,
  input  logic wp_n_pin,
  input  logic hold_n_pin,
  output logic miso_o,
  output logic miso_oe
);

  localparam int PIN_W = 5;
  // Order {cs_n, sck, mosi, wp_n, hold_n}; select and levels idle high.
  localparam logic [PIN_W-1:0] PIN_RST = 5'b10011;

  logic [PIN_W-1:0] pins_s;
  logic             cs_n_s, sck_s, mosi_s, wp_n_s, hold_n_s;
  logic             sel;
  logic             pins_ok;
  logic             sck_rise, sck_fall;
  logic             miso_bit;
  resp_state_e      eng_state;

  pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n_pin, sck_pin, mosi_pin, wp_n_pin, hold_n_pin}),
    .q    (pins_s)
  );

  assign {cs_n_s, sck_s, mosi_s, wp_n_s, hold_n_s} = pins_s;
  assign sel     = ~cs_n_s;
  assign pins_ok = wp_n_s & hold_n_s;

  sck_edge_detect #(
    .RST_LEVEL(PIN_RST[3])
  ) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sck_s (sck_s),
    .enable(pins_ok),
    .rise  (sck_rise),
    .fall  (sck_fall)
  );

  id_engine #(
    .OPCODE  (OPCODE),
    .FILL    (FILL),
    .ID_BYTES(ID_BYTES),
    .ID_VALUE(ID_VALUE)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .rise    (sck_rise),
    .fall    (sck_fall),
    .mosi_bit(mosi_s),
    .miso_bit(miso_bit),
    .state   (eng_state)
  );

  assign miso_o  = miso_bit;
  assign miso_oe = sel;

endmodule

// File: rtl/flash_id_responder_chk.sv
module flash_id_responder_chk
  import flash_id_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n_pin,
  input logic        miso_o,
  input logic        miso_oe,
  input logic        sel_w,
  input logic        sck_rise_w,
  input logic        sck_fall_w,
  input resp_state_e state_w
);

  assert_deselect_oe_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n_pin, 1) && $past(cs_n_pin, 2) && $past(cs_n_pin, 3)) |-> !miso_oe);

  assert_select_oe_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n_pin, 1) && !$past(cs_n_pin, 2) && !$past(cs_n_pin, 3)) |-> miso_oe);

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_w |=> miso_o);

  assert_miso_only_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w && $past(sel_w) && !$past(sck_fall_w)) |-> $stable(miso_o));

  assert_fill_drives_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w && state_w == ST_FILL && sck_fall_w) |=> miso_o);

  assert_rise_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_w |-> !$past(sck_fall_w));

  assert_fall_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall_w |-> !$past(sck_rise_w));

endmodule

bind flash_id_responder flash_id_responder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n_pin  (cs_n_pin),
  .miso_o    (miso_o),
  .miso_oe   (miso_oe),
  .sel_w     (sel),
  .sck_rise_w(sck_rise),
  .sck_fall_w(sck_fall),
  .state_w   (eng_state)
);

// File: tb/flash_id_responder_tb.sv
`timescale 1ns/1ps
module flash_id_responder_tb;

  localparam int HP = 8;  // serial half period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic miso, miso_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_id_responder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_pin  (cs_n),
    .sck_pin   (sck),
    .mosi_pin  (mosi),
    .wp_n_pin  (wp_n),
    .hold_n_pin(hold_n),
    .miso_o    (miso),
    .miso_oe   (miso_oe)
  );

  // {cpol, opcode, five expected bytes: command time + four after}
  localparam logic [48:0] VEC [5] = '{
    {1'b0, 8'h9F, 40'hFF_01_40_13_FF},
    {1'b1, 8'h9F, 40'hFF_01_40_13_FF},
    {1'b0, 8'h9E, 40'hFF_FF_FF_FF_FF},
    {1'b1, 8'h1F, 40'hFF_FF_FF_FF_FF},
    {1'b1, 8'h00, 40'hFF_FF_FF_FF_FF}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic select(input logic cpol);
    sck = cpol;
    wait_n(HP);
    cs_n = 1'b0;
    wait_n(HP);
  endtask

  task automatic deselect(input logic cpol);
    wait_n(HP);
    cs_n = 1'b1;
    wait_n(2*HP);
    sck = cpol;
  endtask

  // Sends the top nbits of tx; MISO sampled just before each rising edge.
  task automatic xfer(input logic cpol, input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 7; b > 7 - nbits; b--) begin
      if (cpol) sck = 1'b0;
      mosi = tx[b];
      wait_n(HP);
      rx[b] = miso;
      sck = 1'b1;
      wait_n(HP);
      if (!cpol) sck = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rx;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);

    // R1: reset / deselected state
    check1("R1 reset oe", miso_oe, 1'b0);
    check1("R1 reset line", miso, 1'b1);

    // Table walk: R2 R3 R4 R5 across modes 0 and 3 (R7)
    for (int v = 0; v < 5; v++) begin
      logic        cpol;
      logic [7:0]  opc;
      logic [39:0] exp;
      {cpol, opc, exp} = VEC[v];
      select(cpol);
      check1("R1 oe when selected", miso_oe, 1'b1);
      xfer(cpol, opc, 8, rx);
      check8("R2 R7 command-time byte", rx, exp[39:32]);
      for (int k = 1; k < 5; k++) begin
        xfer(cpol, 8'hA5, 8, rx);
        if (opc == 8'h9F && k < 4) check8("R3 R7 identity byte", rx, exp[39-8*k -: 8]);
        else if (opc == 8'h9F)     check8("R4 after identity", rx, exp[39-8*k -: 8]);
        else                       check8("R5 unknown command", rx, exp[39-8*k -: 8]);
      end
      deselect(cpol);
      check1("R1 oe after deselect", miso_oe, 1'b0);
      check1("R1 line after deselect", miso, 1'b1);
    end

    // R6: abort halfway through the command, then a fresh command
    select(1'b0);
    xfer(1'b0, 8'h9F, 4, rx);
    check8("R6 partial command bits", rx & 8'hF0, 8'hF0);
    deselect(1'b0);
    select(1'b0);
    xfer(1'b0, 8'h9F, 8, rx);
    check8("R6 fresh command byte", rx, 8'hFF);
    xfer(1'b0, 8'h00, 8, rx);
    check8("R6 fresh identity byte 0", rx, 8'h01);
    xfer(1'b0, 8'h00, 8, rx);
    check8("R6 fresh identity byte 1", rx, 8'h40);
    deselect(1'b0);

    // R6: abort inside the identity, next selection sends an unknown command
    select(1'b1);
    xfer(1'b1, 8'h9F, 8, rx);
    xfer(1'b1, 8'h00, 8, rx);
    check8("R6 first identity byte", rx, 8'h01);
    deselect(1'b1);
    select(1'b1);
    xfer(1'b1, 8'h00, 8, rx);
    xfer(1'b1, 8'h00, 8, rx);
    check8("R6 no stale identity", rx, 8'hFF);
    deselect(1'b1);

    // R8: a byte clocked while hold is low leaves no trace
    hold_n = 1'b0;
    select(1'b0);
    xfer(1'b0, 8'h00, 8, rx);
    check8("R8 held byte line", rx, 8'hFF);
    hold_n = 1'b1;
    wait_n(HP);
    xfer(1'b0, 8'h9F, 8, rx);
    check8("R8 command after hold", rx, 8'hFF);
    xfer(1'b0, 8'h00, 8, rx);
    check8("R8 identity after hold", rx, 8'h01);
    deselect(1'b0);

    // R8: same with write-protect low in mode 3
    wp_n = 1'b0;
    select(1'b1);
    xfer(1'b1, 8'h12, 8, rx);
    wp_n = 1'b1;
    wait_n(HP);
    xfer(1'b1, 8'h9F, 8, rx);
    xfer(1'b1, 8'h00, 8, rx);
    check8("R8 identity after protect", rx, 8'h01);
    xfer(1'b1, 8'h00, 8, rx);
    check8("R8 identity byte 1", rx, 8'h40);
    xfer(1'b1, 8'h00, 8, rx);
    check8("R8 identity byte 2", rx, 8'h13);
    deselect(1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule